// File: doc/BRIEF.md
# Tri-State Phase-Frequency Detector Control

This block sits between the reference path and the programmable divider of a frequency synthesizer. It watches the rising edges of a reference clock and of the divided oscillator clock, both sampled in the system clock domain. From them it works out which signal is running ahead and produces charge-pump commands as three-state digital pairs. Each pair is a drive-enable and a level, and a deasserted enable means the pin floats.

There are three pairs. The main pump drives high when the divided oscillator is faster and low when it is slower. A companion pump uses the opposite polarity. A sub-pump helps the loop lock quickly, and it has four modes: off, two modes that act only on wide mismatch pulses, and a mode that follows the main pump.

A mismatch pulse that lasts longer than a programmable window sets a sticky unlock flag, which is cleared by an explicit strobe. A stop control, or the hold pin low while hold is enabled, floats every pump and discards any pending phase state. An optional dead zone suppresses the first cycles of each mismatch pulse.

Top module: `tristate_pfd`

## Requirements
- R1: A rising edge on `vcoIn` with no reference edge pending makes the main pump drive high (`mainEn`=1, `mainLvl`=1) from the clock edge that samples it. The pulse lasts until a reference edge arrives.
- R2: A rising edge on `refIn` with no oscillator edge pending makes the main pump drive low (`mainEn`=1, `mainLvl`=0).
- R3: Once both edges have been seen, or when both arrive in the same cycle, the pending state clears and all pumps float (enable 0, level 0).
- R4: The inverse pump has the same enable as the main pump and the opposite level. Its level is 1 exactly when the reference leads.
- R5: When `pllStop`=1, or when `holdEn`=1 and `holdPin`=0, all enables are 0 at once and the pending state is discarded. With `holdEn`=0 the hold pin has no effect.
- R6: With `dzEn`=1, the main and inverse pumps stay floating for the first DZ_CYCLES cycles of a mismatch pulse.
- R7: With `subMode`=00 the sub-pump always floats. With `subMode`=11 it copies the main pump's enable and level.
- R8: With `subMode`=01 the sub-pump drives, with the main pump's direction, only once the pulse has lasted more than UNLOCK_WIN cycles. With `subMode`=10 the threshold is UNLOCK_WIN/2 cycles. Dead zone does not apply to these two modes.
- R9: A mismatch pulse lasting more than UNLOCK_WIN cycles, with the pumps not forced off, sets `unlockFlag` one cycle later.
- R10: `unlockFlag` holds until `clrUnlock` is sampled high. A set condition in the same cycle wins over the clear.
- R11: Under reset all enables, levels and `unlockFlag` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| refIn | input | 1 | Selected reference clock, synchronous to clk |
| vcoIn | input | 1 | Divided oscillator clock, synchronous to clk |
| holdPin | input | 1 | Hold pin level; low requests hold |
| holdEn | input | 1 | Enables the hold pin |
| pllStop | input | 1 | Stops the loop and floats all pumps |
| subMode | input | 2 | Sub-pump mode: 00 off, 01 full window, 10 half window, 11 follow main |
| dzEn | input | 1 | Dead-zone enable |
| clrUnlock | input | 1 | Clears the unlock flag |
| mainEn | output | 1 | Main pump drive enable |
| mainLvl | output | 1 | Main pump level |
| invEn | output | 1 | Inverse pump drive enable |
| invLvl | output | 1 | Inverse pump level |
| subEn | output | 1 | Sub-pump drive enable |
| subLvl | output | 1 | Sub-pump level |
| unlockFlag | output | 1 | Sticky unlock indicator |

## Verification
A wrong pending-phase flop appears on the main and inverse pairs in the cycle after the edge that should have set or cleared it. It shows as a pump driving in the wrong direction or floating when it should drive. A wrong pulse-width count does not show until later: it moves the cycle in which the sub-pump starts in modes 01 and 10, and the cycle in which `unlockFlag` rises. These errors surface only on pulses longer than the window, so the random stimulus uses widely mismatched periods. A lost hold or stop gate is visible at once on every enable.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
  typedef struct packed {
    logic vcoRise;
    logic refRise;
    logic forceOff;
    logic clrFlag;
  } pfdStrobe_t;
endpackage

// File: rtl/pfd_ctrl.sv
module pfd_ctrl
  import pfd_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       refIn,
  input  logic       vcoIn,
  input  logic       holdPin,
  input  logic       holdEn,
  input  logic       pllStop,
  input  logic       clrUnlock,
  output pfdStrobe_t stb
);
  logic refPrev, vcoPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      refPrev <= 1'b0;
      vcoPrev <= 1'b0;
    end else begin
      refPrev <= refIn;
      vcoPrev <= vcoIn;
    end
  end

  always_comb begin
    stb.vcoRise  = vcoIn & ~vcoPrev;
    stb.refRise  = refIn & ~refPrev;
    stb.forceOff = pllStop | (holdEn & ~holdPin);
    stb.clrFlag  = clrUnlock;
  end
endmodule

// File: rtl/pfd_datapath.sv
module pfd_datapath
  import pfd_pkg::*;
#(
  parameter int UNLOCK_WIN = 8,
  parameter int DZ_CYCLES  = 1
) (
  input  logic       clk,
  input  logic       rstN,
  input  pfdStrobe_t stb,
  input  logic [1:0] subMode,
  input  logic       dzEn,
  output logic       mainEn,
  output logic       mainLvl,
  output logic       invEn,
  output logic       invLvl,
  output logic       subEn,
  output logic       subLvl,
  output logic       unlockFlag
);
  localparam int CNT_W = $clog2(UNLOCK_WIN + 1);
  localparam int HALF_WIN = UNLOCK_WIN / 2;
  localparam logic [CNT_W-1:0] WIN_V  = CNT_W'(UNLOCK_WIN);
  localparam logic [CNT_W-1:0] HALF_V = CNT_W'(HALF_WIN);
  localparam logic [CNT_W-1:0] DZ_V   = CNT_W'(DZ_CYCLES);

  logic fastQ, slowQ, flagQ;
  logic [CNT_W-1:0] widthCnt;
  logic fastSet, slowSet, bothSet, fastNext, slowNext;
  logic actNow, actNext, setUnlock, live, dzOk;
  logic [CNT_W-1:0] cntNext;

  always_comb begin
    fastSet  = fastQ | stb.vcoRise;
    slowSet  = slowQ | stb.refRise;
    bothSet  = fastSet & slowSet;
    fastNext = ~stb.forceOff & fastSet & ~bothSet;
    slowNext = ~stb.forceOff & slowSet & ~bothSet;
    actNow   = fastQ | slowQ;
    actNext  = fastNext | slowNext;
    if (!actNext || !actNow) cntNext = '0;
    else if (widthCnt == WIN_V) cntNext = widthCnt;
    else cntNext = widthCnt + 1'b1;
    setUnlock = actNow & (widthCnt >= WIN_V) & ~stb.forceOff;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fastQ    <= 1'b0;
      slowQ    <= 1'b0;
      widthCnt <= '0;
      flagQ    <= 1'b0;
    end else begin
      fastQ    <= fastNext;
      slowQ    <= slowNext;
      widthCnt <= cntNext;
      flagQ    <= setUnlock | (flagQ & ~stb.clrFlag);
    end
  end

  always_comb begin
    live    = ~stb.forceOff & actNow;
    dzOk    = ~dzEn | (widthCnt >= DZ_V);
    mainEn  = live & dzOk;
    mainLvl = mainEn & fastQ;
    invEn   = mainEn;
    invLvl  = mainEn & slowQ;
    unique case (subMode)
      2'b00:   subEn = 1'b0;
      2'b01:   subEn = live & (widthCnt >= WIN_V);
      2'b10:   subEn = live & (widthCnt >= HALF_V);
      default: subEn = mainEn;
    endcase
    subLvl     = subEn & fastQ;
    unlockFlag = flagQ;
  end
endmodule

// File: rtl/tristate_pfd.sv
module tristate_pfd
  import pfd_pkg::*;
#(
  parameter int UNLOCK_WIN = 8,
  parameter int DZ_CYCLES  = 1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       refIn,
  input  logic       vcoIn,
  input  logic       holdPin,
  input  logic       holdEn,
  input  logic       pllStop,
  input  logic [1:0] subMode,
  input  logic       dzEn,
  input  logic       clrUnlock,
  output logic       mainEn,
  output logic       mainLvl,
  output logic       invEn,
  output logic       invLvl,
  output logic       subEn,
  output logic       subLvl,
  output logic       unlockFlag
);
  pfdStrobe_t stb;

  pfd_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .refIn(refIn), .vcoIn(vcoIn),
    .holdPin(holdPin), .holdEn(holdEn), .pllStop(pllStop),
    .clrUnlock(clrUnlock), .stb(stb)
  );

  pfd_datapath #(.UNLOCK_WIN(UNLOCK_WIN), .DZ_CYCLES(DZ_CYCLES)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .subMode(subMode), .dzEn(dzEn),
    .mainEn(mainEn), .mainLvl(mainLvl), .invEn(invEn), .invLvl(invLvl),
    .subEn(subEn), .subLvl(subLvl), .unlockFlag(unlockFlag)
  );
endmodule

// File: rtl/tristate_pfd_chk.sv
module tristate_pfd_chk (
  input logic       clk,
  input logic       rstN,
  input logic       holdPin,
  input logic       holdEn,
  input logic       pllStop,
  input logic [1:0] subMode,
  input logic       clrUnlock,
  input logic       mainEn,
  input logic       mainLvl,
  input logic       invEn,
  input logic       invLvl,
  input logic       subEn,
  input logic       subLvl,
  input logic       unlockFlag
);
  p_float_when_forced_r5: assert property (@(posedge clk) disable iff (!rstN)
    (pllStop || (holdEn && !holdPin)) |-> (!mainEn && !invEn && !subEn));

  p_inverse_polarity_r4: assert property (@(posedge clk) disable iff (!rstN)
    mainEn |-> (invEn && (invLvl != mainLvl)));

  p_float_level_low_r3: assert property (@(posedge clk) disable iff (!rstN)
    !mainEn |-> (!mainLvl && !invLvl && !invEn));

  p_sub_off_r7: assert property (@(posedge clk) disable iff (!rstN)
    (subMode == 2'b00) |-> (!subEn && !subLvl));

  p_flag_sticky_r10: assert property (@(posedge clk) disable iff (!rstN)
    (unlockFlag && !clrUnlock) |=> unlockFlag);

  p_sub_follows_r7: assert property (@(posedge clk) disable iff (!rstN)
    (subMode == 2'b11) |-> (subEn == mainEn && subLvl == mainLvl));
endmodule

bind tristate_pfd tristate_pfd_chk u_chk (
  .clk(clk), .rstN(rstN), .holdPin(holdPin), .holdEn(holdEn),
  .pllStop(pllStop), .subMode(subMode), .clrUnlock(clrUnlock),
  .mainEn(mainEn), .mainLvl(mainLvl), .invEn(invEn), .invLvl(invLvl),
  .subEn(subEn), .subLvl(subLvl), .unlockFlag(unlockFlag)
);

// File: tb/tristate_pfd_tb.sv
module tristate_pfd_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WIN = 8;
  localparam int DZ = 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic refIn = 0, vcoIn = 0, holdPin = 1, holdEn = 0, pllStop = 0;
  logic [1:0] subMode = 2'b11;
  logic dzEn = 0, clrUnlock = 0;
  logic mainEn, mainLvl, invEn, invLvl, subEn, subLvl, unlockFlag;

  int checks = 0, errors = 0;
  bit done = 0;

  int mRefP = 0, mVcoP = 0, mFast = 0, mSlow = 0, mCnt = 0, mFlag = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tristate_pfd #(.UNLOCK_WIN(WIN), .DZ_CYCLES(DZ)) u_dut (
    .clk(clk), .rstN(rstN), .refIn(refIn), .vcoIn(vcoIn), .holdPin(holdPin),
    .holdEn(holdEn), .pllStop(pllStop), .subMode(subMode), .dzEn(dzEn),
    .clrUnlock(clrUnlock), .mainEn(mainEn), .mainLvl(mainLvl), .invEn(invEn),
    .invLvl(invLvl), .subEn(subEn), .subLvl(subLvl), .unlockFlag(unlockFlag)
  );

  function automatic int forcedOff();
    return int'(pllStop | (holdEn & ~holdPin));
  endfunction

  task automatic check(input string req, input string name, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, name, act, exp, $time);
    end
  endtask

  task automatic modelStep();
    int rr, vr, off, fs, ss, b, nf, ns, actQ, actN, setU;
    if (!rstN) begin
      mRefP = 0; mVcoP = 0; mFast = 0; mSlow = 0; mCnt = 0; mFlag = 0;
      return;
    end
    rr = int'(refIn) & ~mRefP & 1;
    vr = int'(vcoIn) & ~mVcoP & 1;
    off = forcedOff();
    fs = mFast | vr; ss = mSlow | rr; b = fs & ss;
    nf = off ? 0 : (fs & ~b & 1);
    ns = off ? 0 : (ss & ~b & 1);
    actQ = mFast | mSlow; actN = nf | ns;
    setU = (actQ && mCnt >= WIN && !off) ? 1 : 0;
    mFlag = setU | (mFlag & ~int'(clrUnlock) & 1);
    mCnt = (!actN || !actQ) ? 0 : (mCnt == WIN ? WIN : mCnt + 1);
    mFast = nf; mSlow = ns;
    mRefP = int'(refIn); mVcoP = int'(vcoIn);
  endtask

  task automatic compareAll();
    int live, me, se;
    live = (rstN && !forcedOff() && (mFast | mSlow)) ? 1 : 0;
    me = (live && (!dzEn || mCnt >= DZ)) ? 1 : 0;
    case (subMode)
      2'b00: se = 0;
      2'b01: se = (live && mCnt >= WIN) ? 1 : 0;
      2'b10: se = (live && mCnt >= WIN/2) ? 1 : 0;
      default: se = me;
    endcase
    check("R1 R2 R3 R5 R6", "mainEn", int'(mainEn), me);
    check("R1 R2 R3", "mainLvl", int'(mainLvl), me & mFast);
    check("R4", "invEn", int'(invEn), me);
    check("R4", "invLvl", int'(invLvl), me & mSlow);
    check("R7 R8", "subEn", int'(subEn), se);
    check("R7 R8", "subLvl", int'(subLvl), se & mFast);
    check("R9 R10", "unlockFlag", int'(unlockFlag), mFlag);
  endtask

  task automatic cyc();
    @(posedge clk);
    modelStep();
    @(negedge clk);
    compareAll();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int refHalf, vcoHalf, refCnt, vcoCnt;
    void'($urandom(32'd4242));
    repeat (3) cyc();
    check("R11", "mainEn reset", int'(mainEn), 0);
    check("R11", "unlockFlag reset", int'(unlockFlag), 0);
    rstN = 1'b1;
    cyc();

    // R1: oscillator edge first
    vcoIn = 1; cyc();
    check("R1", "mainLvl vco lead", int'(mainLvl), 1);
    check("R4", "invLvl vco lead", int'(invLvl), 0);
    // R3: reference closes the pulse
    refIn = 1; cyc();
    check("R3", "mainEn after match", int'(mainEn), 0);
    vcoIn = 0; refIn = 0; cyc();

    // R2: reference edge first, held long enough to unlock (R9, R8)
    subMode = 2'b10;
    refIn = 1; cyc();
    check("R2", "mainLvl ref lead", int'(mainLvl), 0);
    check("R2", "mainEn ref lead", int'(mainEn), 1);
    repeat (WIN + 2) cyc();
    check("R9", "unlockFlag wide pulse", int'(unlockFlag), 1);
    check("R8", "subEn half window", int'(subEn), 1);
    // R5: hold pin low without enable has no effect, then with enable floats
    holdPin = 0; cyc();
    check("R5", "mainEn hold not enabled", int'(mainEn), 1);
    holdEn = 1; #1;
    check("R5", "mainEn hold enabled", int'(mainEn), 0);
    cyc();
    holdEn = 0; holdPin = 1; cyc();
    check("R5", "pending discarded", int'(mainEn), 0);
    // R10: sticky then cleared
    check("R10", "flag sticky", int'(unlockFlag), 1);
    clrUnlock = 1; cyc(); clrUnlock = 0; cyc();
    check("R10", "flag cleared", int'(unlockFlag), 0);
    refIn = 0; cyc();

    // R3: simultaneous edges produce no pulse
    refIn = 1; vcoIn = 1; cyc();
    check("R3", "same-cycle edges", int'(mainEn), 0);
    refIn = 0; vcoIn = 0; cyc();

    // R6: dead zone hides first cycle
    dzEn = 1; subMode = 2'b11;
    vcoIn = 1; cyc();
    check("R6", "dead zone first cycle", int'(mainEn), 0);
    cyc();
    check("R6", "dead zone second cycle", int'(mainEn), 1);
    refIn = 1; cyc(); refIn = 0; vcoIn = 0; dzEn = 0; cyc();

    // Random segments with mismatched periods
    refCnt = 0; vcoCnt = 0;
    for (int seg = 0; seg < 40; seg++) begin
      refHalf = 2 + int'($urandom % 14);
      vcoHalf = 2 + int'($urandom % 14);
      subMode = 2'($urandom % 4);
      dzEn = 1'($urandom % 2);
      holdEn = 1'($urandom % 2);
      for (int i = 0; i < 300; i++) begin
        refCnt++; vcoCnt++;
        if (refCnt >= refHalf) begin refCnt = 0; refIn = ~refIn; end
        if (vcoCnt >= vcoHalf) begin vcoCnt = 0; vcoIn = ~vcoIn; end
        if ($urandom % 60 == 0) holdPin = ~holdPin;
        pllStop = ($urandom % 100 == 0);
        clrUnlock = ($urandom % 40 == 0);
        cyc();
      end
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule